// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Byte Lanes

This block is a cycle-accurate, synthesizable model of a single-clock synchronous static RAM. Each rising clock edge is decoded into one operation: deselect, start of a burst from an external address, continuation of the running burst, stall, or sleep. A single load/advance strobe does two jobs. When low it loads a new address, and the chip enables and write enable choose the kind of access. When high it steps the running burst to its next beat, and the beat keeps the kind of access the burst started with.

The burst counter is two bits wide and steps the two low address bits through four beats, then wraps. A static mode input chooses linear order (add the count) or interleaved order (XOR the count). Writes are masked per byte lane. Each lane is eight data bits plus one parity bit, and a lane is written only when its active-low select is asserted. Write data for a beat is taken on the enabled edge that follows the edge that registered the beat's address.

For on-chip use the bidirectional data bus is split into three signals: an input word, an output word and a drive enable. The drive enable is combinational in the output enable, so the output enable acts without waiting for a clock edge.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is asserted, and after it is released until the first read is started, `busDrive` is 0 whatever the value of `oeN`.
- R2: On an enabled edge (`sleep`=0, `cenN`=0) with `advLd`=0, the cycle is a deselect if `ce1N`=1, `ce2`=0 or `ce3N`=1. After that edge `busDrive` is 0.
- R3: After a deselect, an enabled edge with `advLd`=1 stays deselected: no data is driven and no memory word changes, whatever the chip enables, `weN` and `bwN` are.
- R4: An enabled edge with `advLd`=0 and all chip enables asserted loads `addrIn` and starts a burst. The burst is a read when `weN`=1 and a write when `weN`=0.
- R5: An enabled edge with `advLd`=1 during a burst moves to the next beat. Beat k (k = 0..3, wrapping) uses low address bits (base+k) mod 4 when `burstInterleave`=0 and base XOR k when `burstInterleave`=1. The upper address bits do not change, and the beat keeps the read or write kind of the burst.
- R6: An edge with `cenN`=1 is ignored. The address, burst state, pending write and output data all hold, and the next enabled edge goes on from where the burst stopped.
- R7: While `sleep`=1, every other input is ignored at the clock edge and `busDrive` is 0.
- R8: Lane i is bits [9i+8:9i], with the parity bit at 9i+8. On a write beat, lane i of the addressed word is written only when `bwN[i]`=0. Any mix of lanes is allowed, and `bwN`=4'b1111 writes nothing.
- R9: While the current cycle is a write, `busDrive` is 0 whatever the value of `oeN`.
- R10: `busDrive` is 1 exactly when the current cycle is a read, `oeN`=0 and `sleep`=0. It follows `oeN` without any clock edge, and while it is 1, `busOut` holds the word at the current beat address.
- R11: The data of a write beat is the value of `busIn` at the next enabled edge after the edge that registered the beat's address. The value present at the address edge is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Sleep: ignore all inputs, release bus |
| cenN | input | 1 | Active-low clock enable; high stalls |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| advLd | input | 1 | 0 = load new address, 1 = advance burst |
| weN | input | 1 | Active-low write enable, sampled at load |
| bwN | input | 4 | Active-low byte-lane write selects |
| oeN | input | 1 | Asynchronous active-low output enable |
| burstInterleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addrIn | input | 6 | External word address |
| busIn | input | 36 | Bus value seen by the RAM (write data) |
| busOut | output | 36 | Read data presented to the bus |
| busDrive | output | 1 | 1 when the RAM drives the bus |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a write data commit and a new address load: the commit of the previous beat and the start of a read on that same word share one edge, so the read must return the newly written lanes. The bench provokes this with back-to-back write and read starts in the directed phase, and with random cycles in which loads, advances, stalls and sleeps are mixed freely. The second pair is a change of the output enable and a read in flight: the bench changes `oeN` in the middle of a read cycle and judges `busDrive` before the next edge. Every random cycle is compared with a lane-masked reference array that the bench keeps.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rdShow;    // drive read data onto the bus
    logic wrCommit;  // commit write data at this edge
  } strobe_t;

  // low two address bits of burst beat cnt
  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic interleave);
    burstLow = interleave ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              cenN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              advLd,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic              burstInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LANES-1:0]  wrLane
);

  localparam int CNT_W = 2;

  opKind_t            opCur, opNext;
  logic [ADDR_W-1:0]  baseQ, baseNext;
  logic [CNT_W-1:0]   cntQ, cntNext;
  logic [LANES-1:0]   laneQ;
  logic               selected;
  logic               advance;

  assign selected = !ce1N && ce2 && !ce3N;
  assign advance  = !cenN && !sleep;

  always_comb begin
    opNext   = opCur;
    baseNext = baseQ;
    cntNext  = cntQ;
    if (!advLd) begin
      if (!selected) begin
        opNext = OP_IDLE;
      end else begin
        opNext   = weN ? OP_READ : OP_WRITE;
        baseNext = addrIn;
        cntNext  = '0;
      end
    end else if (opCur != OP_IDLE) begin
      cntNext = cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opCur <= OP_IDLE;
      baseQ <= '0;
      cntQ  <= '0;
      laneQ <= '0;
    end else if (advance) begin
      opCur <= opNext;
      baseQ <= baseNext;
      cntQ  <= cntNext;
      laneQ <= ~bwN;
    end
  end

  assign curAddr = {baseQ[ADDR_W-1:CNT_W],
                    burstLow(baseQ[CNT_W-1:0], cntQ, burstInterleave)};
  assign wrLane  = laneQ;

  always_comb begin
    strobe.rdShow   = (opCur == OP_READ) && !oeN && !sleep;
    strobe.wrCommit = (opCur == OP_WRITE) && advance;
  end

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  strobe_t                 strobe,
  input  logic [ADDR_W-1:0]       curAddr,
  input  logic [LANES-1:0]        wrLane,
  input  logic [LANES*LANE_W-1:0] busIn,
  output logic [LANES*LANE_W-1:0] busOut,
  output logic                    busDrive
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.wrCommit && wrLane[g]) begin
        laneMem[curAddr] <= busIn[g*LANE_W +: LANE_W];
      end
    end

    assign busOut[g*LANE_W +: LANE_W] = laneMem[curAddr];
  end

  assign busDrive = strobe.rdShow;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              cenN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              advLd,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic              burstInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive
);

  strobe_t           strobe;
  logic [ADDR_W-1:0] curAddr;
  logic [LANES-1:0]  wrLane;

  sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .sleep(sleep), .cenN(cenN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .advLd(advLd), .weN(weN),
    .bwN(bwN), .oeN(oeN), .burstInterleave(burstInterleave),
    .addrIn(addrIn), .strobe(strobe), .curAddr(curAddr), .wrLane(wrLane)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .strobe(strobe), .curAddr(curAddr), .wrLane(wrLane),
    .busIn(busIn), .busOut(busOut), .busDrive(busDrive)
  );

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleep,
  input logic              cenN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              advLd,
  input logic              weN,
  input logic              oeN,
  input logic [DATA_W-1:0] busOut,
  input logic              busDrive
);

  logic enEdge;
  logic deselLoad;
  logic writeLoad;
  assign enEdge    = !cenN && !sleep;
  assign deselLoad = enEdge && !advLd && (ce1N || !ce2 || ce3N);
  assign writeLoad = enEdge && !advLd && !ce1N && ce2 && !ce3N && !weN;

  // R2
  deselect_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    deselLoad |=> !busDrive);

  // R3
  deselect_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    deselLoad ##1 (enEdge && advLd) |=> !busDrive);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cenN && !sleep) |=> $stable(busOut));

  // R7
  sleep_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !busDrive);

  // R9
  write_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeLoad |=> !busDrive);

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> !oeN);

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .cenN(cenN), .ce1N(ce1N),
  .ce2(ce2), .ce3N(ce3N), .advLd(advLd), .weN(weN), .oeN(oeN),
  .busOut(busOut), .busDrive(busDrive)
);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;

  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sleep = 1'b0, cenN = 1'b0;
  logic          ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic          advLd = 1'b0, weN = 1'b1, oeN = 1'b0, burstInterleave = 1'b0;
  logic [NL-1:0] bwN = '1;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] busIn = '0;
  logic [DW-1:0] busOut;
  logic          busDrive;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sync_burst_sram dut (
    .clk(clk), .rstN(rstN), .sleep(sleep), .cenN(cenN), .ce1N(ce1N),
    .ce2(ce2), .ce3N(ce3N), .advLd(advLd), .weN(weN), .bwN(bwN), .oeN(oeN),
    .burstInterleave(burstInterleave), .addrIn(addrIn), .busIn(busIn),
    .busOut(busOut), .busDrive(busDrive)
  );

  // reference model: 0 idle, 1 read, 2 write
  logic [DW-1:0] refMem [DEPTH];
  int            mOp = 0;
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt = '0;
  logic [NL-1:0] mLane = '0;
  string         tagNow = "";

  function automatic logic [AW-1:0] beatAddr(logic [AW-1:0] b, logic [1:0] c, logic il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ c) : 2'((b[1:0] + c) & 2'd3);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] laneMerge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NL-1:0] en);
    logic [DW-1:0] r;
    r = old;
    for (int i = 0; i < NL; i++) if (en[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    if (!sleep && !cenN) begin
      if (mOp == 2) refMem[beatAddr(mBase, mCnt, burstInterleave)] =
        laneMerge(refMem[beatAddr(mBase, mCnt, burstInterleave)], busIn, mLane);
      if (!advLd) begin
        if (ce1N || !ce2 || ce3N) mOp = 0;
        else begin
          mOp = weN ? 1 : 2;
          mBase = addrIn;
          mCnt = 0;
        end
      end else if (mOp != 0) mCnt = mCnt + 2'd1;
      mLane = ~bwN;
    end
  endtask

  // one clock: inputs already set, model at the edge, compare after it
  task automatic tick();
    string tag;
    logic expDrive;
    @(posedge clk);
    modelEdge();
    #2;
    if (tagNow != "") tag = tagNow;
    else if (sleep) tag = "R7";
    else if (cenN) tag = "R6";
    else if (mOp == 2) tag = "R9";
    else if (mOp == 0) tag = advLd ? "R3" : "R2";
    else tag = advLd ? "R5" : "R4";
    expDrive = (mOp == 1) && !oeN && !sleep;
    check({tag, " drive"}, DW'(busDrive), DW'(expDrive));
    if (expDrive) check({tag, " data"}, busOut, refMem[beatAddr(mBase, mCnt, burstInterleave)]);
  endtask

  task automatic setIdle();
    sleep = 0; cenN = 0; advLd = 0; ce1N = 1; ce2 = 1; ce3N = 0; weN = 1; bwN = '1;
  endtask

  task automatic startOp(logic [AW-1:0] a, logic wr, logic [NL-1:0] bw);
    sleep = 0; cenN = 0; advLd = 0; ce1N = 0; ce2 = 1; ce3N = 0;
    weN = ~wr; bwN = bw; addrIn = a;
  endtask

  function automatic logic [DW-1:0] rndWord();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d1, d2, old;
    void'($urandom(32'd4242));
    // R1: reset with output enable active
    oeN = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 in reset", DW'(busDrive), '0);
    rstN = 1;
    setIdle(); advLd = 1;
    tick();
    check("R1 after reset", DW'(busDrive), '0);

    // fill memory with linear write bursts (R4, R5, R11)
    for (int a = 0; a < DEPTH; a += 4) begin
      startOp(AW'(a), 1, '0);
      tick();
      for (int k = 0; k < 4; k++) begin
        busIn = rndWord();
        if (k < 3) begin advLd = 1; bwN = '0; end
        else setIdle();
        tick();
      end
    end

    // R5 linear order from base 5: 5,6,7,4
    burstInterleave = 0;
    startOp(6'd5, 0, '1); oeN = 0; tick();
    check("R4 load read", busOut, refMem[5]);
    advLd = 1; tick();
    check("R5 linear beat1", busOut, refMem[6]);
    tick(); tick();
    check("R5 linear wrap", busOut, refMem[4]);
    // R6 stall holds data, then continues to the next beat
    cenN = 1; tick(); tick();
    check("R6 stall hold", busOut, refMem[4]);
    cenN = 0; tick();
    check("R6 resume wraps", busOut, refMem[5]);

    // R5 interleaved order from base 5: 5,4,7,6
    setIdle(); tick();
    burstInterleave = 1;
    startOp(6'd5, 0, '1); tick();
    advLd = 1; tick();
    check("R5 interleave beat1", busOut, refMem[4]);
    tick();
    check("R5 interleave beat2", busOut, refMem[7]);
    // R10 async output enable during a read
    #1 oeN = 1; #1;
    check("R10 oe off", DW'(busDrive), '0);
    oeN = 0; #1;
    check("R10 oe on", DW'(busDrive), 1);
    // R7 sleep releases bus and holds the burst
    sleep = 1; tick();
    check("R7 sleep release", DW'(busDrive), '0);
    sleep = 0; tick();
    check("R7 resume", busOut, refMem[6]);
    setIdle(); tick();
    burstInterleave = 0;

    // R8 partial lanes 0 and 2, then all selects high
    old = refMem[9];
    d1 = rndWord();
    startOp(6'd9, 1, 4'b1010); oeN = 0; tick();
    check("R9 write release", DW'(busDrive), '0);
    busIn = d1; setIdle(); tick();
    startOp(6'd9, 0, '1); tick();
    check("R8 lanes 0 and 2", busOut, laneMerge(old, d1, 4'b0101));
    old = refMem[9];
    startOp(6'd9, 1, '1); tick();
    busIn = rndWord(); setIdle(); tick();
    startOp(6'd9, 0, '1); tick();
    check("R8 no lanes", busOut, old);

    // R11 data sampled at the edge after the address edge
    d1 = rndWord(); d2 = rndWord();
    busIn = d1; startOp(6'd12, 1, '0); tick();
    busIn = d2; startOp(6'd12, 0, '1); tick();
    check("R11 late data", busOut, d2);

    // R2 each chip enable deselects; R3 advance stays idle and writes nothing
    startOp(6'd20, 0, '1); ce1N = 1; tick();
    check("R2 ce1N", DW'(busDrive), '0);
    startOp(6'd20, 0, '1); ce2 = 0; tick();
    check("R2 ce2", DW'(busDrive), '0);
    startOp(6'd20, 0, '1); ce3N = 1; tick();
    check("R2 ce3N", DW'(busDrive), '0);
    old = refMem[20];
    startOp(6'd20, 1, '0); advLd = 1; busIn = rndWord(); tick();
    check("R3 stays idle", DW'(busDrive), '0);
    busIn = rndWord(); tick();
    startOp(6'd20, 0, '1); tick();
    check("R3 no write", busOut, old);

    // random mix against the reference array
    for (int n = 0; n < 4000; n++) begin
      sleep = ($urandom_range(0, 19) == 0);
      cenN = ($urandom_range(0, 9) == 0);
      advLd = ($urandom_range(0, 2) != 0);
      ce1N = ($urandom_range(0, 7) == 0);
      ce2 = ($urandom_range(0, 7) != 0);
      ce3N = ($urandom_range(0, 7) == 0);
      weN = $urandom_range(0, 1);
      bwN = NL'($urandom);
      oeN = ($urandom_range(0, 4) == 0);
      addrIn = AW'($urandom);
      busIn = rndWord();
      tick();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule